// File: doc/BRIEF.md
# Debug Trigger Chain Resolver

This block turns the raw match results of ten debug triggers into the final decision of whether a debug trap is taken at the commit point. The triggers form five fixed pairs: trigger 2g and trigger 2g+1 make up group g. A per-group chain bit joins the two triggers of a pair so that they fire only together. Each trigger also carries an enable bit and a timing bit. Timing 0 asks for a trap on the current instruction. Timing 1 asks for a trap on the instruction after it.

The pairs have fixed source kinds. Group 0 holds two fetch triggers. Group 1 holds two store triggers and group 2 holds two load triggers. Groups 3 and 4 each hold one fetch trigger at the even index, paired with a store trigger in group 3 and a load trigger in group 4. The summary output ORs together the fire bits of the fetch-side triggers and of the memory-side triggers.

The enable, timing and chain settings live in registers inside the block. A narrow write port updates them at run time, one trigger per cycle. All outputs are registered. A decision therefore appears one cycle after its hit vector is presented. A synchronous clear drops the registered decision when the pipeline is flushed.

Top module: `trg_chain_resolver`

## Requirements
- R1: For an unchained group, each trigger's fire bit is its enable AND its hit bit, evaluated with its own timing. The result appears on `fire_vec` one clock after `hit_vec` is presented.
- R2: For a chained group, neither trigger fires unless both triggers are enabled and both hit bits are set. When those conditions hold, both fire bits are set together.
- R3: For a chained group whose two timing bits differ, neither trigger fires, even when both triggers are enabled and hit.
- R4: `fire_now` is 1 when at least one firing trigger has timing 0.
- R5: `fire_next` is 1 when at least one firing trigger has timing 1 and no firing trigger has timing 0. Fire-now has priority, so the two flags are never 1 together.
- R6: `any_hit` is the OR of the fetch-side fire bits (triggers 0, 1, 6 and 8) and the memory-side fire bits (triggers 2, 3, 4, 5, 7 and 9). It is therefore 1 exactly when `fire_vec` is nonzero.
- R7: A write with `cfg_we`=1 and `cfg_idx`=k (k<10) sets trigger k's enable to `cfg_enable` and its timing to `cfg_timing`. It also sets the chain bit of group k/2 to `cfg_chain`. The new settings govern hits presented from the next cycle on.
- R8: A write with `cfg_idx` from 10 to 15 changes no setting.
- R9: `clr`=1 at a clock edge leaves `fire_vec`, `fire_now`, `fire_next` and `any_hit` all 0 after that edge, whatever the hit vector is.
- R10: After reset, every trigger is disabled with timing 0 and every group is unchained. All outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the registered decision (pipeline flush) |
| hit_vec | input | 10 | Raw per-trigger match bits |
| cfg_we | input | 1 | Settings write strobe |
| cfg_idx | input | 4 | Trigger index addressed by the write |
| cfg_enable | input | 1 | New enable bit of the addressed trigger |
| cfg_timing | input | 1 | New timing bit (0 current, 1 next instruction) |
| cfg_chain | input | 1 | New chain bit of the addressed trigger's group |
| fire_vec | output | 10 | Registered per-trigger fire bits |
| fire_now | output | 1 | A firing trigger requests a trap on the current instruction |
| fire_next | output | 1 | A firing trigger requests a trap on the next instruction (and none on the current one) |
| any_hit | output | 1 | OR of all fetch-side and memory-side fire bits |

## Verification
The bench builds the block with its default of five pairs and a 4-bit index. This makes the full pair table, both kinds of source triggers, and the six unused index codes 10 to 15 reachable. One fixed setting gives the five groups different modes at the same time: an unchained pair with mixed timing, a chained pair whose timings disagree, a chained next-instruction pair, an unchained pair with one trigger disabled, and a chained pair from the mixed fetch/load group. The vector table can therefore reach suppression, AND-combination and fire-now priority within a single hit pattern.

// File: rtl/trg_pkg.sv
package trg_pkg;

    typedef enum logic [1:0] {
        SRC_FETCH = 2'd0,
        SRC_LOAD  = 2'd1,
        SRC_STORE = 2'd2
    } trg_src_e;

    // Source kind of a trigger, fixed by its group.
    function automatic trg_src_e trig_src(input int unsigned t);
        trg_src_e k;
        case (t / 2)
            0:       k = SRC_FETCH;
            1:       k = SRC_STORE;
            2:       k = SRC_LOAD;
            3:       k = (t % 2 == 0) ? SRC_FETCH : SRC_STORE;
            4:       k = (t % 2 == 0) ? SRC_FETCH : SRC_LOAD;
            default: k = SRC_LOAD;
        endcase
        return k;
    endfunction

    function automatic logic trig_is_fetch(input int unsigned t);
        return trig_src(t) == SRC_FETCH;
    endfunction

    typedef struct packed {
        logic hit;
        logic en;
        logic tim;
    } trg_in_t;

endpackage

// File: rtl/trg_cfg_regs.sv
module trg_cfg_regs #(
    parameter int unsigned NUM_PAIRS = 5,
    parameter int unsigned IDX_W     = 4,
    localparam int unsigned NUM_TRIG = 2 * NUM_PAIRS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 wr_enable,
    input  logic                 wr_timing,
    input  logic                 wr_chain,
    output logic [NUM_TRIG-1:0]  en_q,
    output logic [NUM_TRIG-1:0]  tim_q,
    output logic [NUM_PAIRS-1:0] chain_q
);

    for (genvar k = 0; k < NUM_TRIG; k++) begin : g_trig
        logic sel;
        assign sel = we && (idx == IDX_W'(k));
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[k]  <= 1'b0;
                tim_q[k] <= 1'b0;
            end else if (sel) begin
                en_q[k]  <= wr_enable;
                tim_q[k] <= wr_timing;
            end
        end
    end

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        logic sel;
        assign sel = we && ((idx == IDX_W'(2 * g)) || (idx == IDX_W'(2 * g + 1)));
        always_ff @(posedge clk) begin
            if (rst)
                chain_q[g] <= 1'b0;
            else if (sel)
                chain_q[g] <= wr_chain;
        end
    end

endmodule

// File: rtl/trg_pair_resolve.sv
module trg_pair_resolve
    import trg_pkg::*;
(
    input  trg_in_t    lo,
    input  trg_in_t    hi,
    input  logic       chained,
    output logic [1:0] fire
);

    logic lo_act, hi_act, both_ok;

    always_comb begin
        lo_act  = lo.hit && lo.en;
        hi_act  = hi.hit && hi.en;
        both_ok = lo_act && hi_act && (lo.tim == hi.tim);
        if (chained)
            fire = {both_ok, both_ok};
        else
            fire = {hi_act, lo_act};
    end

endmodule

// File: rtl/trg_chain_resolver.sv
module trg_chain_resolver
    import trg_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 5,
    parameter int unsigned IDX_W     = 4,
    localparam int unsigned NUM_TRIG = 2 * NUM_PAIRS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic [NUM_TRIG-1:0] hit_vec,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic                cfg_enable,
    input  logic                cfg_timing,
    input  logic                cfg_chain,
    output logic [NUM_TRIG-1:0] fire_vec,
    output logic                fire_now,
    output logic                fire_next,
    output logic                any_hit
);

    logic [NUM_TRIG-1:0]  en_q;
    logic [NUM_TRIG-1:0]  tim_q;
    logic [NUM_PAIRS-1:0] chain_q;
    logic [NUM_TRIG-1:0]  fire_d;
    logic                 now_d, next_d, fe_any, be_any;

    trg_cfg_regs #(.NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .idx       (cfg_idx),
        .wr_enable (cfg_enable),
        .wr_timing (cfg_timing),
        .wr_chain  (cfg_chain),
        .en_q      (en_q),
        .tim_q     (tim_q),
        .chain_q   (chain_q)
    );

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        trg_in_t lo, hi;
        assign lo = '{hit: hit_vec[2*g],   en: en_q[2*g],   tim: tim_q[2*g]};
        assign hi = '{hit: hit_vec[2*g+1], en: en_q[2*g+1], tim: tim_q[2*g+1]};
        trg_pair_resolve u_res (
            .lo      (lo),
            .hi      (hi),
            .chained (chain_q[g]),
            .fire    (fire_d[2*g+1:2*g])
        );
    end

    always_comb begin
        fe_any = 1'b0;
        be_any = 1'b0;
        for (int k = 0; k < NUM_TRIG; k++) begin
            if (trig_is_fetch(k))
                fe_any = fe_any | fire_d[k];
            else
                be_any = be_any | fire_d[k];
        end
        now_d  = |(fire_d & ~tim_q);
        next_d = |(fire_d & tim_q) && !now_d;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fire_vec  <= '0;
            fire_now  <= 1'b0;
            fire_next <= 1'b0;
            any_hit   <= 1'b0;
        end else begin
            fire_vec  <= fire_d;
            fire_now  <= now_d;
            fire_next <= next_d;
            any_hit   <= fe_any | be_any;
        end
    end

endmodule

// File: rtl/trg_chain_resolver_chk.sv
module trg_chain_resolver_chk #(
    parameter int unsigned NUM_PAIRS = 5,
    parameter int unsigned IDX_W     = 4,
    localparam int unsigned NUM_TRIG = 2 * NUM_PAIRS
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 clr,
    input logic [NUM_TRIG-1:0]  hit_vec,
    input logic                 cfg_we,
    input logic [IDX_W-1:0]     cfg_idx,
    input logic [NUM_TRIG-1:0]  en_q,
    input logic [NUM_TRIG-1:0]  tim_q,
    input logic [NUM_PAIRS-1:0] chain_q,
    input logic [NUM_TRIG-1:0]  fire_vec,
    input logic                 fire_now,
    input logic                 fire_next,
    input logic                 any_hit
);

    // R5
    now_next_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fire_now && fire_next));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (fire_vec == '0 && !fire_now && !fire_next && !any_hit));

    // R6
    summary_or_chk: assert property (@(posedge clk) disable iff (rst)
        any_hit == (fire_vec != '0));

    // R8
    high_idx_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_idx >= IDX_W'(NUM_TRIG)) |=>
            ($stable(en_q) && $stable(tim_q) && $stable(chain_q)));

    for (genvar k = 0; k < NUM_TRIG; k++) begin : g_trig
        // R1
        gated_fire_chk: assert property (@(posedge clk) disable iff (rst)
            !(hit_vec[k] && en_q[k]) |=> !fire_vec[k]);
    end

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        // R2
        chain_together_chk: assert property (@(posedge clk) disable iff (rst)
            chain_q[g] |=> (fire_vec[2*g] == fire_vec[2*g+1]));
        // R3
        timing_clash_chk: assert property (@(posedge clk) disable iff (rst)
            (chain_q[g] && (tim_q[2*g] != tim_q[2*g+1])) |=>
                (!fire_vec[2*g] && !fire_vec[2*g+1]));
    end

endmodule

bind trg_chain_resolver trg_chain_resolver_chk #(
    .NUM_PAIRS(NUM_PAIRS),
    .IDX_W(IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .hit_vec   (hit_vec),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .en_q      (en_q),
    .tim_q     (tim_q),
    .chain_q   (chain_q),
    .fire_vec  (fire_vec),
    .fire_now  (fire_now),
    .fire_next (fire_next),
    .any_hit   (any_hit)
);

// File: tb/trg_chain_resolver_test.sv
module trg_chain_resolver_test;

    localparam int NP = 5;
    localparam int NT = 2 * NP;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic [NT-1:0] hit_vec = '0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_idx = '0;
    logic          cfg_enable = 1'b0;
    logic          cfg_timing = 1'b0;
    logic          cfg_chain = 1'b0;
    logic [NT-1:0] fire_vec;
    logic          fire_now, fire_next, any_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    trg_chain_resolver #(.NUM_PAIRS(NP), .IDX_W(4)) uut (
        .clk(clk), .rst(rst), .clr(clr), .hit_vec(hit_vec),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_enable(cfg_enable),
        .cfg_timing(cfg_timing), .cfg_chain(cfg_chain),
        .fire_vec(fire_vec), .fire_now(fire_now), .fire_next(fire_next),
        .any_hit(any_hit)
    );

    // Setting: enable all but trigger 7; timing 1 on 1,3,4,5,7,8,9;
    // chained groups 1, 2 and 4.
    localparam logic [NT-1:0] EN_SET  = 10'h37F;
    localparam logic [NT-1:0] TIM_SET = 10'h3BA;
    localparam logic [NP-1:0] CH_SET  = 5'b10110;

    // {hit, expected fire, expected now, expected next}
    localparam int NV = 12;
    localparam logic [21:0] VEC [NV] = '{
        {10'h000, 10'h000, 1'b0, 1'b0},  // R1 idle
        {10'h001, 10'h001, 1'b1, 1'b0},  // R1 R4 unchained timing 0
        {10'h002, 10'h002, 1'b0, 1'b1},  // R1 R5 unchained timing 1
        {10'h003, 10'h003, 1'b1, 1'b0},  // R5 priority of now
        {10'h00C, 10'h000, 1'b0, 1'b0},  // R3 timing clash
        {10'h010, 10'h000, 1'b0, 1'b0},  // R2 one side only
        {10'h030, 10'h030, 1'b0, 1'b1},  // R2 both sides
        {10'h080, 10'h000, 1'b0, 1'b0},  // R1 disabled trigger
        {10'h040, 10'h040, 1'b1, 1'b0},  // R1 fetch side in group 3
        {10'h300, 10'h300, 1'b0, 1'b1},  // R2 fetch/load chained
        {10'h100, 10'h000, 1'b0, 1'b0},  // R2 one side only
        {10'h3FF, 10'h373, 1'b1, 1'b0}   // R3 R4 R6 all hits
    };

    task automatic check(input string req, input logic [NT-1:0] ef,
                         input logic en, input logic enx);
        logic ea;
        ea = (ef != '0);
        checks++;
        if (fire_vec !== ef || fire_now !== en || fire_next !== enx || any_hit !== ea) begin
            fails++;
            $display("FAIL %s: fire=%h now=%b next=%b any=%b expected fire=%h now=%b next=%b any=%b",
                     req, fire_vec, fire_now, fire_next, any_hit, ef, en, enx, ea);
        end
    endtask

    task automatic write_cfg(input logic [3:0] idx, input logic e,
                             input logic t, input logic c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_enable = e; cfg_timing = t; cfg_chain = c;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Present a hit vector for one edge, then check at the following negedge.
    task automatic apply(input logic [NT-1:0] h, input logic [NT-1:0] ef,
                         input logic en, input logic enx, input string req);
        @(negedge clk);
        hit_vec = h;
        @(negedge clk);
        check(req, ef, en, enx);
        hit_vec = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset outputs", '0, 1'b0, 1'b0);
        rst = 1'b0;
        // R10: defaults disable every trigger
        apply(10'h3FF, 10'h000, 1'b0, 1'b0, "R10 disabled after reset");

        // R7: program the setting
        for (int k = 0; k < NT; k++)
            write_cfg(4'(k), EN_SET[k], TIM_SET[k], CH_SET[k/2]);

        for (int v = 0; v < NV; v++)
            apply(VEC[v][21:12], VEC[v][11:2], VEC[v][1], VEC[v][0],
                  $sformatf("R7 table row %0d", v));

        // R8: writes to codes 10..15 change nothing
        for (int k = NT; k < 16; k++)
            write_cfg(4'(k), 1'b0, 1'b0, 1'b0);
        apply(10'h3FF, 10'h373, 1'b1, 1'b0, "R8 high index ignored");
        apply(10'h030, 10'h030, 1'b0, 1'b1, "R8 group 2 still chained");

        // R7: unchain group 2 through a write to trigger 4
        write_cfg(4'd4, 1'b1, 1'b1, 1'b0);
        apply(10'h010, 10'h010, 1'b0, 1'b1, "R7 unchained single fire");
        // R7: rewrite trigger 0 to timing 1
        write_cfg(4'd0, 1'b1, 1'b1, 1'b0);
        apply(10'h001, 10'h001, 1'b0, 1'b1, "R7 timing rewrite");

        // R9: clear wins over a live hit
        @(negedge clk);
        hit_vec = 10'h040; clr = 1'b1;
        @(negedge clk);
        check("R9 clear", '0, 1'b0, 1'b0);
        clr = 1'b0;
        @(negedge clk);
        check("R9 after clear", 10'h040, 1'b1, 1'b0);
        hit_vec = '0;
        @(negedge clk);
        check("R1 idle after hit removed", '0, 1'b0, 1'b0);

        // R10: reset again mid-run
        @(negedge clk);
        rst = 1'b1; hit_vec = 10'h3FF;
        @(negedge clk);
        check("R10 reset clears outputs", '0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 setting cleared by reset", '0, 1'b0, 1'b0);
        hit_vec = '0;
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule